// File: doc/BRIEF.md
# Routed Set/Clear Interrupt Aggregator

This block gathers sixteen interrupt request lines from the engine around a small processor and turns them into two request wires for the processor core (vector 0 and vector 1) and two interrupt wires toward the host (output A and output B). Each line is either edge-sensitive or level-sensitive, chosen per line by a mode register. An edge-sensitive line keeps a sticky pending bit. That bit is raised by a rising input or by software and dropped by software. A level-sensitive line shows its input wire directly as its pending bit.

Software reaches the block through a simple word-addressed register bus with a write strobe and a combinational read port. The pending mask and the enable mask are each exposed as three addresses: a write-one-to-set address, a write-one-to-clear address and a read-only status address. A routing register gives every line a 2-bit destination selector. Each output is the OR, over the lines routed to it, of pending AND enabled. The outputs are combinational, so a change in state shows up in the same cycle.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the edge pending bits, the enable mask and the routing register are zero, the mode register reads 0x0000FC04, and all four outputs are low.
- R2: For a line in edge mode (mode bit 0), a 0-to-1 change of its input, seen between two consecutive clock edges, sets its pending bit at the next edge. The bit stays set after the input falls.
- R3: For an edge-mode line, writing 1 to its bit at offset 0x00 sets the pending bit, and writing 1 at offset 0x04 clears it. When a clear write and a rising input reach the same line in the same cycle, the bit ends up set.
- R4: For a line in level mode (mode bit 1), bit i of the pending status at offset 0x08 equals input i in the same cycle. Writes at 0x00 and 0x04 do not change that status.
- R5: The mode register at offset 0x0C takes bits 15:0 of a write (bit i = 1 selects level mode for line i). Bits 31:16 read as zero.
- R6: The enable mask is set by writing ones at 0x10, cleared by writing ones at 0x14, and reads back at 0x18.
- R7: The routing register at 0x1C holds selector bit 0 of line i in bit i and selector bit 1 in bit 16+i. A selector of 0 routes to vec_req[0], 1 to host_irq[0], 2 to vec_req[1] and 3 to host_irq[1].
- R8: Each of vec_req[1:0] and host_irq[1:0] is high exactly when at least one line routed to it is both pending and enabled. The result appears combinationally from the current state and inputs.
- R9: Clearing a line's enable bit leaves its pending bit unchanged. Setting the enable bit again raises the routed output while the line is still pending.
- R10: Reads of offsets 0x00, 0x04, 0x10 and 0x14 return zero. A write to the pending status offset 0x08 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | Interrupt input lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address, byte offset bits 4:2 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| vec_req | output | 2 | Requests to processor vector 0 and vector 1 |
| host_irq | output | 2 | Host interrupt outputs A (bit 0) and B (bit 1) |

## Verification
The hardest cases to reach from the ports are the ones where two sources hit the same pending bit in one cycle: a rising input together with a clear write, and edges on a line that is currently in level mode, which still load the hidden edge flop. The hidden edge flop only becomes visible after the mode is flipped back. Directed steps line up the input edge with the clear write on the same clock. A long random phase then mixes mode rewrites with input toggles and set/clear writes, so stale edge state shows up later at the status port and on the outputs. A behavioural model is compared against the outputs on every cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int NLINES  = 16;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 5;
    localparam logic [NLINES-1:0] MODE_RST = 16'hFC04;

    typedef enum logic [2:0] {
        REG_PSET  = 3'd0,
        REG_PCLR  = 3'd1,
        REG_PSTAT = 3'd2,
        REG_MODE  = 3'd3,
        REG_ESET  = 3'd4,
        REG_ECLR  = 3'd5,
        REG_ESTAT = 3'd6,
        REG_ROUTE = 3'd7
    } reg_idx_e;

    typedef enum logic [1:0] {
        DST_VEC0  = 2'd0,
        DST_HOSTA = 2'd1,
        DST_VEC1  = 2'd2,
        DST_HOSTB = 2'd3
    } dest_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int                N        = 16,
    parameter logic [N-1:0]      MODE_RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line_in,
    input  logic [N-1:0] set_m,
    input  logic [N-1:0] clr_m,
    input  logic         mode_we,
    input  logic [N-1:0] mode_wdata,
    output logic [N-1:0] pend,
    output logic [N-1:0] mode
);
    typedef struct packed {
        logic [N-1:0] latch;
        logic [N-1:0] prev;
        logic [N-1:0] mode;
    } pend_st_t;

    pend_st_t st_d, st_q;
    logic [N-1:0] rise;

    always_comb begin
        st_d       = st_q;
        rise       = line_in & ~st_q.prev;
        st_d.prev  = line_in;
        st_d.latch = (st_q.latch & ~(clr_m & ~st_q.mode))
                   | (set_m & ~st_q.mode)
                   | rise;
        if (mode_we) st_d.mode = mode_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.latch <= '0;
            st_q.prev  <= '0;
            st_q.mode  <= MODE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = (st_q.mode & line_in) | (~st_q.mode & st_q.latch);
    assign mode = st_q.mode;

    // R2
    edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(line_in & ~st_q.prev & ~st_q.mode)) |=>
        ((pend & $past(line_in & ~st_q.prev & ~st_q.mode) & ~st_q.mode)
            == ($past(line_in & ~st_q.prev & ~st_q.mode) & ~st_q.mode)));

    // R3
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_m & ~st_q.mode & ~(line_in & ~st_q.prev))) |=>
        ((st_q.latch & $past(clr_m & ~st_q.mode & ~(line_in & ~st_q.prev))) == '0));

    // R4
    level_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & st_q.mode & ~line_in) == '0));
endmodule

// File: rtl/irq_route_bank.sv
module irq_route_bank #(
    parameter int N = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   pend,
    input  logic [N-1:0]   en_set,
    input  logic [N-1:0]   en_clr,
    input  logic           route_we,
    input  logic [2*N-1:0] route_wdata,
    output logic [N-1:0]   en,
    output logic [2*N-1:0] route,
    output logic [1:0]     vec_req,
    output logic [1:0]     host_irq
);
    import irq_agg_pkg::*;

    typedef struct packed {
        logic [N-1:0]   en;
        logic [2*N-1:0] route;
    } route_st_t;

    route_st_t    st_d, st_q;
    logic [N-1:0] live;
    logic [N-1:0] to_v0, to_v1, to_ha, to_hb;

    always_comb begin
        st_d    = st_q;
        st_d.en = (st_q.en | en_set) & ~en_clr;
        if (route_we) st_d.route = route_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign live = pend & st_q.en;

    for (genvar i = 0; i < N; i++) begin : g_line
        dest_e sel;
        assign sel      = dest_e'({st_q.route[N+i], st_q.route[i]});
        assign to_v0[i] = live[i] && (sel == DST_VEC0);
        assign to_ha[i] = live[i] && (sel == DST_HOSTA);
        assign to_v1[i] = live[i] && (sel == DST_VEC1);
        assign to_hb[i] = live[i] && (sel == DST_HOSTB);
    end

    assign vec_req  = {|to_v1, |to_v0};
    assign host_irq = {|to_hb, |to_ha};
    assign en       = st_q.en;
    assign route    = st_q.route;

    // R8
    no_spurious_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & en) == '0) |-> (vec_req == 2'b00 && host_irq == 2'b00));

    // R8
    single_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pend & en) == 1) |-> $onehot({vec_req, host_irq}));

    // R6
    enable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|en_set) |=> ((en & $past(en_set)) == $past(en_set)));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NLINES-1:0]    irq_in,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:2]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [1:0]           vec_req,
    output logic [1:0]           host_irq
);
    localparam int RW = 2 * NLINES;

    reg_idx_e          idx;
    logic [NLINES-1:0] wmask, p_set, p_clr, e_set, e_clr;
    logic              mode_we, route_we;
    logic [NLINES-1:0] pend, mode, en;
    logic [RW-1:0]     route;

    assign idx      = reg_idx_e'(bus_addr);
    assign wmask    = bus_wdata[NLINES-1:0];
    assign p_set    = (bus_wr && idx == REG_PSET) ? wmask : '0;
    assign p_clr    = (bus_wr && idx == REG_PCLR) ? wmask : '0;
    assign e_set    = (bus_wr && idx == REG_ESET) ? wmask : '0;
    assign e_clr    = (bus_wr && idx == REG_ECLR) ? wmask : '0;
    assign mode_we  = bus_wr && idx == REG_MODE;
    assign route_we = bus_wr && idx == REG_ROUTE;

    irq_pend_bank #(.N(NLINES), .MODE_RST(MODE_RST)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_in    (irq_in),
        .set_m      (p_set),
        .clr_m      (p_clr),
        .mode_we    (mode_we),
        .mode_wdata (wmask),
        .pend       (pend),
        .mode       (mode)
    );

    irq_route_bank #(.N(NLINES)) u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend        (pend),
        .en_set      (e_set),
        .en_clr      (e_clr),
        .route_we    (route_we),
        .route_wdata (bus_wdata[RW-1:0]),
        .en          (en),
        .route       (route),
        .vec_req     (vec_req),
        .host_irq    (host_irq)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (idx)
            REG_PSTAT: bus_rdata[NLINES-1:0] = pend;
            REG_MODE:  bus_rdata[NLINES-1:0] = mode;
            REG_ESTAT: bus_rdata[NLINES-1:0] = en;
            REG_ROUTE: bus_rdata[RW-1:0]     = route;
            default:   bus_rdata = '0;
        endcase
    end

    // R10
    write_only_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == REG_PSET || idx == REG_PCLR || idx == REG_ESET || idx == REG_ECLR)
        |-> (bus_rdata == '0));
endmodule

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  vec_req, host_irq;

    int nvec = 0;
    int nfail = 0;
    bit done = 0;

    // behavioural reference state
    logic [15:0] m_latch, m_prev, m_mode, m_en;
    logic [31:0] m_route;

    always #10 clk = ~clk;

    irq_aggregator dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .vec_req(vec_req), .host_irq(host_irq)
    );

    function automatic logic [15:0] ref_pend();
        logic [15:0] p;
        for (int i = 0; i < 16; i++)
            p[i] = m_mode[i] ? irq_in[i] : m_latch[i];
        return p;
    endfunction

    function automatic logic [31:0] ref_rdata();
        case (bus_addr)
            3'd2: return {16'h0, ref_pend()};
            3'd3: return {16'h0, m_mode};
            3'd6: return {16'h0, m_en};
            3'd7: return m_route;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [3:0] ref_outs();
        logic [3:0] o = '0; // {vec1, hostB? no: index by selector}
        logic [15:0] p = ref_pend();
        for (int i = 0; i < 16; i++) begin
            int s = {m_route[16+i], m_route[i]};
            if (p[i] && m_en[i]) o[s] = 1'b1;
        end
        return o; // o[0]=vec0, o[1]=hostA, o[2]=vec1, o[3]=hostB
    endfunction

    task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
        nvec++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic compare(string tag);
        logic [3:0] o = ref_outs();
        check(tag, "rdata", bus_rdata, ref_rdata());
        check(tag, "vec_req", {30'h0, vec_req}, {30'h0, o[2], o[0]});
        check(tag, "host_irq", {30'h0, host_irq}, {30'h0, o[3], o[1]});
    endtask

    task automatic step(string tag, logic [15:0] irq, logic wr, logic [4:0] off, logic [31:0] d);
        logic [15:0] dm;
        irq_in = irq; bus_wr = wr; bus_addr = off[4:2]; bus_wdata = d;
        #1;
        compare(tag);
        @(posedge clk);
        dm = d[15:0];
        for (int i = 0; i < 16; i++) begin
            logic up = irq[i] && !m_prev[i];
            if (wr && off[4:2] == 3'd1 && dm[i] && !m_mode[i]) m_latch[i] = 1'b0;
            if (wr && off[4:2] == 3'd0 && dm[i] && !m_mode[i]) m_latch[i] = 1'b1;
            if (up) m_latch[i] = 1'b1;
            m_prev[i] = irq[i];
            if (wr && off[4:2] == 3'd4 && dm[i]) m_en[i] = 1'b1;
            if (wr && off[4:2] == 3'd5 && dm[i]) m_en[i] = 1'b0;
        end
        if (wr && off[4:2] == 3'd3) m_mode = dm;
        if (wr && off[4:2] == 3'd7) m_route = d;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        m_latch = '0; m_prev = '0; m_mode = 16'hFC04; m_en = '0; m_route = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        step("R1", 16'h0, 0, 5'h0C, 0);
        check("R1", "mode reset", bus_rdata, 32'h0000FC04);
        check("R1", "outputs", {28'h0, vec_req, host_irq}, 32'h0);

        // R6 enable triple
        step("R6", 16'h0, 1, 5'h10, 32'hFFFF);
        step("R6", 16'h0, 0, 5'h18, 0);
        check("R6", "enable status", bus_rdata, 32'h0000FFFF);

        // R2 edge capture, held after input falls
        step("R2", 16'h0001, 0, 5'h08, 0);
        check("R2", "pending after rise", bus_rdata, 32'h1);
        check("R2", "vec_req", {30'h0, vec_req}, 32'h1);
        step("R2", 16'h0000, 0, 5'h08, 0);
        check("R2", "pending held", bus_rdata, 32'h1);

        // R3 set/clear writes and clear-vs-edge
        step("R3", 16'h0, 1, 5'h04, 32'h1);
        step("R3", 16'h0, 0, 5'h08, 0);
        check("R3", "cleared", bus_rdata, 32'h0);
        step("R3", 16'h0, 1, 5'h00, 32'h2);
        step("R3", 16'h0, 0, 5'h08, 0);
        check("R3", "sw set", bus_rdata, 32'h2);
        step("R3", 16'h0002, 1, 5'h04, 32'h2);
        step("R3", 16'h0002, 0, 5'h08, 0);
        check("R3", "edge beats clear", bus_rdata, 32'h2);
        step("R3", 16'h0000, 1, 5'h04, 32'h2);
        step("R3", 16'h0000, 0, 5'h08, 0);
        check("R3", "cleared again", bus_rdata, 32'h0);

        // R4 level line 2 follows input, writes ignored
        step("R4", 16'h0, 1, 5'h00, 32'h4);
        step("R4", 16'h0, 0, 5'h08, 0);
        check("R4", "set ignored", bus_rdata, 32'h0);
        step("R4", 16'h4, 0, 5'h08, 0);
        check("R4", "follows high", bus_rdata, 32'h4);
        step("R4", 16'h4, 1, 5'h04, 32'h4);
        step("R4", 16'h4, 0, 5'h08, 0);
        check("R4", "clear ignored", bus_rdata, 32'h4);
        step("R4", 16'h0, 0, 5'h08, 0);
        check("R4", "follows low", bus_rdata, 32'h0);

        // R7 routing selectors
        step("R7", 16'h0, 1, 5'h1C, 32'h00000001);
        step("R7", 16'h0, 1, 5'h00, 32'h1);
        step("R7", 16'h0, 0, 5'h08, 0);
        check("R7", "sel1 host A", {28'h0, vec_req, host_irq}, 32'h1);
        step("R7", 16'h0, 1, 5'h1C, 32'h00010001);
        check("R7", "sel3 host B", {28'h0, vec_req, host_irq}, 32'h2);
        step("R7", 16'h0, 1, 5'h1C, 32'h00010000);
        check("R7", "sel2 vec 1", {28'h0, vec_req, host_irq}, 32'h8);

        // R9 masking keeps pending
        step("R9", 16'h0, 1, 5'h14, 32'h1);
        check("R9", "masked outputs", {28'h0, vec_req, host_irq}, 32'h0);
        step("R9", 16'h0, 0, 5'h08, 0);
        check("R9", "still pending", bus_rdata, 32'h1);
        step("R9", 16'h0, 1, 5'h10, 32'h1);
        check("R9", "redelivered", {30'h0, vec_req}, 32'h2);

        // R10 write-only offsets read zero, status write ignored
        step("R10", 16'h0, 0, 5'h00, 0);
        check("R10", "set reads zero", bus_rdata, 32'h0);
        step("R10", 16'h0, 1, 5'h08, 32'hFFFF);
        step("R10", 16'h0, 0, 5'h08, 0);
        check("R10", "status unchanged", bus_rdata, 32'h1);

        // R5 mode register width
        step("R5", 16'h0, 1, 5'h0C, 32'h00012345);
        step("R5", 16'h0, 0, 5'h0C, 0);
        check("R5", "mode readback", bus_rdata, 32'h00002345);

        // R8 random mix compared against the model every cycle
        for (int k = 0; k < 4000; k++) begin
            logic [15:0] irq = 16'($urandom) & 16'($urandom);
            logic        wr  = ($urandom % 3) == 0;
            logic [4:0]  off = {3'($urandom % 8), 2'b00};
            logic [31:0] d   = $urandom;
            step("R8", irq, wr, off, d);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule